// File: doc/BRIEF.md
# PLL Synthesizer Register Load Sequencer

This block loads a three-latch integer-N frequency synthesizer through a write-only serial link and then confirms that the loop has locked. A single start pulse captures a prescaler code, a reference divider and a total feedback divide count. The block splits the count into a coarse counter B and a fine counter A using the selected dual-modulus prescaler. It then assembles three 24-bit words, reference, control and feedback, and sends each in its own chip-select frame.

The first load after reset inserts a long settle delay between the control frame and the feedback frame; later loads go straight through. After the feedback frame, the lock-detect input is sampled. If it is low, the block waits a retry interval and samples once more. A split with B smaller than A is refused before any frame goes out. A separate power-down request rewrites the control latch alone, with its power-down field set. The delay lengths are parameters derived from the clock rate, so a testbench may shorten them.

Top module: `pll_load_seq`

## Requirements
- R1: Every frame holds exactly 24 bits, sent most significant bit first while spi_csn is low. spi_sclk idles low, and spi_mosi stays stable while spi_sclk is high, so the receiver samples on the rising edge.
- R2: Bits 1:0 of each word carry the latch address: 2'b01 for the reference word, 2'b00 for the control word and 2'b10 for the feedback word.
- R3: A normal load sends three frames in a fixed order: reference first, control second, feedback third.
- R4: On the first accepted load after reset, the gap from the end of the control frame to the start of the feedback frame is at least SETTLE_CYC cycles. On every later load, the gap is shorter than SETTLE_CYC.
- R5: The control word carries the prescaler code at bits 23:22, the value 0 at bits 21:20 for a normal load, CTRL_MISC at bits 19:2 and 2'b00 at bits 1:0.
- R6: The prescaler modulus P is 8 for code 0, 16 for code 1 and 32 for codes 2 and 3. The feedback word carries N_HI at bits 23:21, B = floor(n/P) at bits 20:8, 0 at bit 7, A = n - P*B at bits 6:2 and 2'b10 at bits 1:0.
- R7: The reference word carries R_HI at bits 23:16, the reference divider at bits 15:2 and 2'b01 at bits 1:0.
- R8: When B < A, no frame is sent, done pulses with split_err = 1 and lock_ok = 0. When B equals A, the load proceeds normally.
- R9: Lock handling:
  - If lock_in is high at the first sample, done follows within RETRY_CYC cycles of the feedback frame, with lock_ok = 1.
  - If the first sample is low, a second sample is taken at least RETRY_CYC cycles later, and lock_ok equals that second sample.
- R10: A power-down request sends exactly one frame: a control word with bits 21:20 = 3. It then pulses done, with lock_ok = 0 and split_err = 0.
- R11: busy rises in the cycle after an accepted start and falls in the same cycle that done pulses. A start that arrives while busy is high has no effect.
- R12: After reset, spi_csn = 1, spi_sclk = 0, and busy, done, lock_ok and split_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a full load |
| pdown_req | input | 1 | Request to rewrite the control latch in power-down |
| presc_sel | input | 2 | Prescaler code, captured at start |
| ref_div | input | 14 | Reference divider value, captured at start |
| fb_count | input | 18 | Total feedback divide count n, captured at start |
| lock_in | input | 1 | Lock-detect input from the synthesizer |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_csn | output | 1 | Active-low frame select |
| busy | output | 1 | High while a load or power-down is in progress |
| done | output | 1 | One-cycle completion pulse |
| lock_ok | output | 1 | Lock result of the last operation |
| split_err | output | 1 | Last load was refused because B < A |

## Verification
Full loads are driven with every prescaler code, so the shift-based split is exercised for each modulus. Codes 2 and 3 must both yield a modulus of 32. A split with B far below A must produce no frame at all, while the B equal to A boundary must still load; these two cases separate the rejection compare from an off-by-one error. The same parameters are loaded twice after reset, which distinguishes a one-time settle delay from one that is always or never applied. The lock input is driven as high, low then high, and always low; this tells the fast path apart from a retry that is skipped or taken, and shows which sample decides the result. A power-down request and a start pulse issued mid-load complete the set: they reveal a wrong frame count, a wrong power-down field, or a second load that should have been ignored.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int WORD_W = 24;
  localparam int REF_W  = 14;
  localparam int B_W    = 13;
  localparam int A_W    = 5;
  localparam int FB_W   = B_W + A_W;

  typedef enum logic [1:0] {
    LATCH_CTRL = 2'd0,
    LATCH_REF  = 2'd1,
    LATCH_FB   = 2'd2
  } latch_t;

  // log2 of the dual-modulus prescaler for a given code
  function automatic int unsigned presc_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 3;
      2'd1:    return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/plm_split.sv
module plm_split
  import plm_pkg::*;
(
  input  logic [1:0]      presc,
  input  logic [FB_W-1:0] fb,
  output logic [B_W-1:0]  b_cnt,
  output logic [A_W-1:0]  a_cnt,
  output logic            bad
);
  logic [FB_W-1:0] full_b;
  logic [FB_W-1:0] full_a;
  logic [FB_W-1:0] mask;

  always_comb begin
    mask   = (FB_W'(1) << presc_shift(presc)) - FB_W'(1);
    full_b = fb >> presc_shift(presc);
    full_a = fb & mask;
    bad    = full_b < full_a;
    b_cnt  = full_b[B_W-1:0];
    a_cnt  = full_a[A_W-1:0];
  end
endmodule

// File: rtl/plm_words.sv
module plm_words
  import plm_pkg::*;
#(
  parameter logic [7:0]  R_HI      = 8'h34,
  parameter logic [17:0] CTRL_MISC = 18'h3F249,
  parameter logic [2:0]  N_HI      = 3'b000
) (
  input  latch_t            sel,
  input  logic [1:0]        presc,
  input  logic [1:0]        pd_code,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [B_W-1:0]    b_cnt,
  input  logic [A_W-1:0]    a_cnt,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    case (sel)
      LATCH_REF: word = {R_HI, ref_div, LATCH_REF};
      LATCH_FB:  word = {N_HI, b_cnt, 1'b0, a_cnt, LATCH_FB};
      default:   word = {presc, pd_code, CTRL_MISC, LATCH_CTRL};
    endcase
  end
endmodule

// File: rtl/plm_spi_tx.sv
module plm_spi_tx
  import plm_pkg::*;
#(
  parameter int SCLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              mosi,
  output logic              csn,
  output logic              fin
);
  localparam int CW = $clog2(SCLK_HALF + 1);
  localparam int NW = $clog2(WORD_W);
  localparam logic [CW-1:0] HALF_LAST = CW'(SCLK_HALF - 1);
  localparam logic [NW-1:0] BIT_LAST  = NW'(WORD_W - 1);

  typedef enum logic [1:0] {T_IDLE, T_LO, T_HI, T_TAIL} tx_st_t;

  tx_st_t            st;
  logic [CW-1:0]     cnt;
  logic [NW-1:0]     nbit;
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= T_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sreg <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      csn  <= 1'b1;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        T_IDLE: if (go) begin
          csn  <= 1'b0;
          mosi <= word[WORD_W-1];
          sreg <= word << 1;
          cnt  <= '0;
          nbit <= '0;
          st   <= T_LO;
        end
        T_LO: if (cnt == HALF_LAST) begin
          cnt  <= '0;
          sclk <= 1'b1;
          st   <= T_HI;
        end else cnt <= cnt + 1'b1;
        T_HI: if (cnt == HALF_LAST) begin
          cnt  <= '0;
          sclk <= 1'b0;
          if (nbit == BIT_LAST) st <= T_TAIL;
          else begin
            mosi <= sreg[WORD_W-1];
            sreg <= sreg << 1;
            nbit <= nbit + 1'b1;
            st   <= T_LO;
          end
        end else cnt <= cnt + 1'b1;
        default: if (cnt == HALF_LAST) begin
          cnt <= '0;
          csn <= 1'b1;
          fin <= 1'b1;
          st  <= T_IDLE;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/plm_ctrl.sv
module plm_ctrl
  import plm_pkg::*;
#(
  parameter int SETTLE_CYC = 1000,
  parameter int RETRY_CYC  = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       pdown,
  input  logic       split_bad,
  input  logic       spi_fin,
  input  logic       lock_in,
  output logic       cap,
  output logic       spi_go,
  output latch_t     sel,
  output logic [1:0] pd_code,
  output logic       busy,
  output logic       done,
  output logic       lock_ok,
  output logic       err
);
  localparam int MAXD = (SETTLE_CYC > RETRY_CYC) ? SETTLE_CYC : RETRY_CYC;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] RTY_LAST = CW'(RETRY_CYC - 1);

  typedef enum logic [2:0] {
    C_IDLE, C_CHECK, C_SEND, C_WAIT, C_SETTLE, C_LOCK1, C_RETRY, C_LOCK2
  } ctl_st_t;

  ctl_st_t       st;
  logic [CW-1:0] dcnt;
  logic          first_q;
  logic          pd_mode;

  assign cap = (st == C_IDLE) && (start || pdown);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= C_IDLE;
      dcnt    <= '0;
      first_q <= 1'b1;
      pd_mode <= 1'b0;
      spi_go  <= 1'b0;
      sel     <= LATCH_REF;
      pd_code <= 2'd0;
      busy    <= 1'b0;
      done    <= 1'b0;
      lock_ok <= 1'b0;
      err     <= 1'b0;
    end else begin
      spi_go <= 1'b0;
      done   <= 1'b0;
      case (st)
        C_IDLE: begin
          if (start) begin
            busy    <= 1'b1;
            pd_mode <= 1'b0;
            lock_ok <= 1'b0;
            err     <= 1'b0;
            st      <= C_CHECK;
          end else if (pdown) begin
            busy    <= 1'b1;
            pd_mode <= 1'b1;
            lock_ok <= 1'b0;
            err     <= 1'b0;
            pd_code <= 2'd3;
            sel     <= LATCH_CTRL;
            st      <= C_SEND;
          end
        end
        C_CHECK: begin
          if (split_bad) begin
            err  <= 1'b1;
            done <= 1'b1;
            busy <= 1'b0;
            st   <= C_IDLE;
          end else begin
            pd_code <= 2'd0;
            sel     <= LATCH_REF;
            st      <= C_SEND;
          end
        end
        C_SEND: begin
          spi_go <= 1'b1;
          st     <= C_WAIT;
        end
        C_WAIT: if (spi_fin) begin
          if (pd_mode) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= C_IDLE;
          end else begin
            case (sel)
              LATCH_REF: begin
                sel <= LATCH_CTRL;
                st  <= C_SEND;
              end
              LATCH_CTRL: begin
                if (first_q) begin
                  dcnt <= '0;
                  st   <= C_SETTLE;
                end else begin
                  sel <= LATCH_FB;
                  st  <= C_SEND;
                end
              end
              default: st <= C_LOCK1;
            endcase
          end
        end
        C_SETTLE: begin
          if (dcnt == SET_LAST) begin
            first_q <= 1'b0;
            sel     <= LATCH_FB;
            st      <= C_SEND;
          end else dcnt <= dcnt + 1'b1;
        end
        C_LOCK1: begin
          if (lock_in) begin
            lock_ok <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            st      <= C_IDLE;
          end else begin
            dcnt <= '0;
            st   <= C_RETRY;
          end
        end
        C_RETRY: begin
          if (dcnt == RTY_LAST) st <= C_LOCK2;
          else dcnt <= dcnt + 1'b1;
        end
        default: begin
          lock_ok <= lock_in;
          done    <= 1'b1;
          busy    <= 1'b0;
          st      <= C_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pll_load_seq.sv
module pll_load_seq
  import plm_pkg::*;
#(
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          SETTLE_CYC = CLK_HZ / 100,
  parameter int          RETRY_CYC  = CLK_HZ / 10,
  parameter int          SCLK_HALF  = 4,
  parameter logic [7:0]  R_HI       = 8'h34,
  parameter logic [17:0] CTRL_MISC  = 18'h3F249,
  parameter logic [2:0]  N_HI       = 3'b000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  pdown_req,
  input  logic [1:0]            presc_sel,
  input  logic [REF_W-1:0]      ref_div,
  input  logic [FB_W-1:0]       fb_count,
  input  logic                  lock_in,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  output logic                  spi_csn,
  output logic                  busy,
  output logic                  done,
  output logic                  lock_ok,
  output logic                  split_err
);
  logic [1:0]        presc_q;
  logic [REF_W-1:0]  ref_q;
  logic [FB_W-1:0]   fb_q;
  logic              cap;
  logic [B_W-1:0]    b_cnt;
  logic [A_W-1:0]    a_cnt;
  logic              bad;
  latch_t            sel;
  logic [1:0]        pd_code;
  logic [WORD_W-1:0] word;
  logic              spi_go;
  logic              spi_fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      ref_q   <= '0;
      fb_q    <= '0;
    end else if (cap) begin
      presc_q <= presc_sel;
      ref_q   <= ref_div;
      fb_q    <= fb_count;
    end
  end

  plm_split u_split (
    .presc (presc_q),
    .fb    (fb_q),
    .b_cnt (b_cnt),
    .a_cnt (a_cnt),
    .bad   (bad)
  );

  plm_words #(.R_HI(R_HI), .CTRL_MISC(CTRL_MISC), .N_HI(N_HI)) u_words (
    .sel     (sel),
    .presc   (presc_q),
    .pd_code (pd_code),
    .ref_div (ref_q),
    .b_cnt   (b_cnt),
    .a_cnt   (a_cnt),
    .word    (word)
  );

  plm_spi_tx #(.SCLK_HALF(SCLK_HALF)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .go   (spi_go),
    .word (word),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .csn  (spi_csn),
    .fin  (spi_fin)
  );

  plm_ctrl #(.SETTLE_CYC(SETTLE_CYC), .RETRY_CYC(RETRY_CYC)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pdown     (pdown_req),
    .split_bad (bad),
    .spi_fin   (spi_fin),
    .lock_in   (lock_in),
    .cap       (cap),
    .spi_go    (spi_go),
    .sel       (sel),
    .pd_code   (pd_code),
    .busy      (busy),
    .done      (done),
    .lock_ok   (lock_ok),
    .err       (split_err)
  );
endmodule

// File: rtl/pll_load_seq_chk.sv
module pll_load_seq_chk (
  input logic clk,
  input logic rst,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_csn,
  input logic busy,
  input logic done,
  input logic lock_ok,
  input logic split_err
);
  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    spi_csn |-> !spi_sclk);

  a_r1_mosi_stable: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r11_frame_in_busy: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_csn);

  a_r11_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  a_r8_err_no_lock: assert property (@(posedge clk) disable iff (rst)
    (done && split_err) |-> !lock_ok);
endmodule

bind pll_load_seq pll_load_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_csn   (spi_csn),
  .busy      (busy),
  .done      (done),
  .lock_ok   (lock_ok),
  .split_err (split_err)
);

// File: tb/pll_load_seq_bench.sv
module pll_load_seq_bench;
  localparam int          SETTLE = 200;
  localparam int          RETRY  = 300;
  localparam logic [7:0]  RHI    = 8'h34;
  localparam logic [17:0] MISC   = 18'h3F249;
  localparam logic [2:0]  NHI    = 3'b010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, pdown_req = 1'b0, lock_in = 1'b0;
  logic [1:0]  presc_sel = '0;
  logic [13:0] ref_div = '0;
  logic [17:0] fb_count = '0;
  logic spi_sclk, spi_mosi, spi_csn, busy, done, lock_ok, split_err;

  int errors = 0, checks = 0, cyc = 0, done_cyc = 0;
  int nfr = 0;
  logic        in_fr = 1'b0;
  logic [23:0] shreg = '0;
  int          nbits = 0;
  logic [23:0] fr_word [8];
  int          fr_bits [8];
  int          fr_fall [8];
  int          fr_rise [8];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_load_seq #(.CLK_HZ(1000), .SETTLE_CYC(SETTLE), .RETRY_CYC(RETRY),
                 .SCLK_HALF(2), .R_HI(RHI), .CTRL_MISC(MISC), .N_HI(NHI))
  u_pll_load_seq (
    .clk(clk), .rst(rst), .start(start), .pdown_req(pdown_req),
    .presc_sel(presc_sel), .ref_div(ref_div), .fb_count(fb_count),
    .lock_in(lock_in), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_csn(spi_csn), .busy(busy), .done(done), .lock_ok(lock_ok),
    .split_err(split_err)
  );

  // serial monitor
  always @(negedge spi_csn) begin
    in_fr = 1'b1; shreg = '0; nbits = 0;
    if (nfr < 8) fr_fall[nfr] = cyc;
  end
  always @(posedge spi_sclk) if (in_fr) begin
    shreg = {shreg[22:0], spi_mosi}; nbits = nbits + 1;
  end
  always @(posedge spi_csn) if (in_fr) begin
    in_fr = 1'b0;
    if (nfr < 8) begin
      fr_word[nfr] = shreg; fr_bits[nfr] = nbits; fr_rise[nfr] = cyc;
    end
    nfr = nfr + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_r(input logic [13:0] rd);
    return {RHI, rd, 2'b01};
  endfunction
  function automatic logic [23:0] exp_c(input logic [1:0] pc, input logic [1:0] pd);
    return {pc, pd, MISC, 2'b00};
  endfunction
  function automatic logic [23:0] exp_n(input logic [1:0] pc, input logic [17:0] n);
    int p; int b; int a;
    p = (pc == 2'd0) ? 8 : (pc == 2'd1) ? 16 : 32;
    b = n / p; a = n - p * b;
    return {NHI, 13'(b), 1'b0, 5'(a), 2'b10};
  endfunction

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin done_cyc = cyc; return; end
    end
    chk(1'b0, "done timeout", 0, 1);
  endtask

  task automatic pulse_start(input logic [1:0] pc, input logic [13:0] rd, input logic [17:0] n);
    nfr = 0;
    @(negedge clk);
    presc_sel = pc; ref_div = rd; fb_count = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_frames(input logic [1:0] pc, input logic [13:0] rd, input logic [17:0] n, input string tag);
    chk(nfr == 3, {tag, " R3 frame count"}, nfr, 3);
    for (int k = 0; k < 3; k++) chk(fr_bits[k] == 24, {tag, " R1 bits per frame"}, fr_bits[k], 24);
    chk(fr_word[0] == exp_r(rd), {tag, " R7 R2 R3 reference word"}, fr_word[0], exp_r(rd));
    chk(fr_word[1] == exp_c(pc, 2'd0), {tag, " R5 control word"}, fr_word[1], exp_c(pc, 2'd0));
    chk(fr_word[2] == exp_n(pc, n), {tag, " R6 feedback word"}, fr_word[2], exp_n(pc, n));
  endtask

  task automatic t_reset();
    chk(spi_csn == 1'b1 && spi_sclk == 1'b0, "R12 serial idle", {spi_csn, spi_sclk}, 2'b10);
    chk({busy, done, lock_ok, split_err} == 4'b0, "R12 status clear", {busy, done, lock_ok, split_err}, 0);
  endtask

  task automatic t_first_load();
    lock_in = 1'b1;
    pulse_start(2'd1, 14'd16, 18'd1000);
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    wait_done();
    check_frames(2'd1, 14'd16, 18'd1000, "first");
    chk(fr_fall[2] - fr_rise[1] >= SETTLE, "R4 settle on first load", fr_fall[2] - fr_rise[1], SETTLE);
    chk(lock_ok == 1'b1 && split_err == 1'b0, "R9 lock immediate", {lock_ok, split_err}, 2'b10);
    chk(done_cyc - fr_rise[2] < RETRY, "R9 no retry when locked", done_cyc - fr_rise[2], RETRY);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R11 idle after done", {busy, done}, 0);
  endtask

  task automatic t_later_load(input logic [1:0] pc, input logic [17:0] n, input string tag);
    lock_in = 1'b1;
    pulse_start(pc, 14'h2A5, n);
    wait_done();
    check_frames(pc, 14'h2A5, n, tag);
    chk(fr_fall[2] - fr_rise[1] < SETTLE, {tag, " R4 no settle later"}, fr_fall[2] - fr_rise[1], SETTLE);
  endtask

  task automatic t_split_err();
    pulse_start(2'd2, 14'd16, 18'd20);
    wait_done();
    chk(split_err == 1'b1 && lock_ok == 1'b0, "R8 error reported", {split_err, lock_ok}, 2'b10);
    repeat (20) @(negedge clk);
    chk(nfr == 0, "R8 no frames on error", nfr, 0);
    lock_in = 1'b1;
    pulse_start(2'd0, 14'd7, 18'd45);
    wait_done();
    chk(split_err == 1'b0, "R8 B equal A accepted", split_err, 0);
    check_frames(2'd0, 14'd7, 18'd45, "b_eq_a");
  endtask

  task automatic t_retry(input logic second, input string tag);
    lock_in = 1'b0;
    pulse_start(2'd1, 14'd16, 18'd1234);
    wait (nfr == 3);
    repeat (20) @(negedge clk);
    lock_in = second;
    wait_done();
    chk(lock_ok == second, {tag, " R9 second sample decides"}, lock_ok, second);
    chk(done_cyc - fr_rise[2] >= RETRY, {tag, " R9 retry delay"}, done_cyc - fr_rise[2], RETRY);
  endtask

  task automatic t_pdown();
    nfr = 0;
    @(negedge clk);
    presc_sel = 2'd1; pdown_req = 1'b1;
    @(negedge clk);
    pdown_req = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(nfr == 1, "R10 single frame", nfr, 1);
    chk(fr_word[0] == exp_c(2'd1, 2'd3), "R10 power-down control word", fr_word[0], exp_c(2'd1, 2'd3));
    chk(lock_ok == 1'b0 && split_err == 1'b0, "R10 status", {lock_ok, split_err}, 0);
  endtask

  task automatic t_busy_ignore();
    lock_in = 1'b1;
    pulse_start(2'd0, 14'd9, 18'd100);
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R11 busy during load", busy, 1);
    presc_sel = 2'd2; ref_div = 14'd3; fb_count = 18'd5000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (400) @(negedge clk);
    chk(nfr == 3, "R11 start while busy ignored", nfr, 3);
    chk(fr_word[2] == exp_n(2'd0, 18'd100), "R11 first parameters kept", fr_word[2], exp_n(2'd0, 18'd100));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_load();
    t_later_load(2'd0, 18'd100, "p8");
    t_later_load(2'd2, 18'd2000, "p32 code2");
    t_later_load(2'd3, 18'd1063, "p32 code3");
    t_split_err();
    t_retry(1'b1, "retry_ok");
    t_retry(1'b0, "retry_fail");
    t_pdown();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule